// File: doc/BRIEF.md
# Parallel Byte Crossbar with One-Hot Lane Selects

This block assembles a wide output bus from a shared bank of input bytes. Every output lane picks its byte on its own, so two lanes may show the same input byte, different bytes, or nothing at all, independent of the other lanes. The selection for a lane is a one-hot vector with one bit per input byte, not a binary index. Each data bit of a lane is formed by ANDing that vector with the matching bit of every input byte and OR-reducing the result.

The block is purely combinational. It has no clock and no reset, and the outputs follow the bank and the selects directly. A surrounding design registers the inputs or outputs where its timing needs it, and it is responsible for producing the select vectors. With the default parameters the block takes 240 input bytes of 8 bits and produces 64 output lanes, which needs 15360 select bits.

Top module: `byte_xbar`

## Requirements
- R1: Input byte i sits at `bank_flat[i*W +: W]`. Lane j drives `lanes_flat[j*W +: W]` and is steered by `sel_flat[j*N_IN +: N_IN]`, in which bit i selects input byte i. The defaults are N_IN=240, N_OUT=64 and W=8.
- R2: When a lane's select vector has exactly one bit set, at position i, the lane outputs input byte i.
- R3: Each lane's output depends only on its own select vector and the bank. Several lanes may select the same byte or different bytes at the same time.
- R4: A lane whose select vector is all zero outputs zero.
- R5: When more than one select bit is set, the lane outputs the bitwise OR of all the selected bytes. This is defined but is not intended use.
- R6: The outputs respond to a change of the bank or the selects with no clock edge in between.
- R7: All lanes read one shared bank. Changing one input byte changes exactly the lanes that select it, and leaves the other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bank_flat | input | N_IN*W | Shared input byte bank, byte i at bits [i*W +: W] |
| sel_flat | input | N_OUT*N_IN | Per-lane select vectors, lane j at bits [j*N_IN +: N_IN] |
| lanes_flat | output | N_OUT*W | Output bus, lane j at bits [j*W +: W] |

## Verification
The match check assumes a lane's select vector is one-hot and fires only in that case. The empty-select check and the bank-bound check hold for any select value, so multi-hot vectors are exercised without tripping the assertions. The stimulus uses a small configuration (6 inputs, 3 lanes, 4-bit bytes). It walks every one of the 64 select patterns on each lane, which covers empty, one-hot and multi-hot vectors. It also runs every one-hot combination across the three lanes. The bank is changed only while no clock edge lies between the change and the sample, so the check shows that the outputs follow the inputs directly.

// File: rtl/byte_xbar_pkg.sv
package byte_xbar_pkg;
  localparam int DEF_N_IN  = 240;
  localparam int DEF_N_OUT = 64;
  localparam int DEF_W     = 8;
endpackage

// File: rtl/xbar_col_slicer.sv
// Regroups the bank so that bit b of every input byte forms one column.
// All lanes share these columns.
module xbar_col_slicer #(
  parameter int N_IN = 240,
  parameter int W    = 8
) (
  input  logic [N_IN*W-1:0]          bank_flat,
  output logic [W-1:0][N_IN-1:0]     cols
);
  always_comb begin
    for (int b = 0; b < W; b++) begin
      for (int i = 0; i < N_IN; i++) begin
        cols[b][i] = bank_flat[i*W + b];
      end
    end
  end
endmodule

// File: rtl/xbar_lane.sv
// One output lane: the select vector gates every column, and each column
// is OR-reduced into one data bit.
module xbar_lane #(
  parameter int N_IN = 240,
  parameter int W    = 8
) (
  input  logic [W-1:0][N_IN-1:0] cols,
  input  logic [N_IN-1:0]        sel,
  output logic [W-1:0]           lane_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign lane_out[b] = |(cols[b] & sel);
  end

  always_comb begin
    if (sel == '0) begin
      AST_EMPTY_SEL_ZERO: assert (lane_out == '0) else $error("lane data with empty select"); // R4
    end
    if (lane_out != '0) begin
      AST_DATA_NEEDS_SEL: assert (sel != '0) else $error("lane data without any select bit"); // R4
    end
  end
endmodule

// File: rtl/byte_xbar.sv
module byte_xbar
  import byte_xbar_pkg::*;
#(
  parameter int N_IN  = DEF_N_IN,
  parameter int N_OUT = DEF_N_OUT,
  parameter int W     = DEF_W
) (
  input  logic [N_IN*W-1:0]     bank_flat,
  input  logic [N_OUT*N_IN-1:0] sel_flat,
  output logic [N_OUT*W-1:0]    lanes_flat
);
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [W-1:0][N_IN-1:0] cols;
  logic [W-1:0]           bank_any;

  xbar_col_slicer #(.N_IN(N_IN), .W(W)) u_slicer (
    .bank_flat (bank_flat),
    .cols      (cols)
  );

  // OR of every input byte: no lane may show a bit outside it.
  always_comb begin
    bank_any = '0;
    for (int i = 0; i < N_IN; i++) bank_any |= bank_flat[i*W +: W];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_lane
    logic [N_IN-1:0]  lane_sel;
    logic [W-1:0]     lane_data;
    logic [IDX_W-1:0] pick;

    assign lane_sel = sel_flat[j*N_IN +: N_IN];

    xbar_lane #(.N_IN(N_IN), .W(W)) u_lane (
      .cols     (cols),
      .sel      (lane_sel),
      .lane_out (lane_data)
    );

    assign lanes_flat[j*W +: W] = lane_data;

    // Binary index of the highest set select bit, used only by the check below.
    always_comb begin
      pick = '0;
      for (int i = 0; i < N_IN; i++) if (lane_sel[i]) pick = IDX_W'(i);
    end

    always_comb begin
      if ($onehot(lane_sel)) begin
        AST_ONEHOT_MATCH: assert (lane_data == bank_flat[int'(pick)*W +: W]) else $error("lane %0d wrong byte", j); // R2
      end
      AST_LANE_IN_BANK: assert ((lane_data & ~bank_any) == '0) else $error("lane %0d bit outside bank", j); // R5
    end
  end
endmodule

// File: tb/byte_xbar_tb.sv
module byte_xbar_tb_top;
  localparam int NI = 6;
  localparam int NO = 3;
  localparam int WB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [WB-1:0] bank_m [NI];
  logic [NI-1:0] sel_m  [NO];
  logic [NI*WB-1:0] bank_flat;
  logic [NO*NI-1:0] sel_flat;
  logic [NO*WB-1:0] lanes_flat;

  always_comb begin
    for (int i = 0; i < NI; i++) bank_flat[i*WB +: WB] = bank_m[i];
    for (int j = 0; j < NO; j++) sel_flat[j*NI +: NI] = sel_m[j];
  end

  byte_xbar #(.N_IN(NI), .N_OUT(NO), .W(WB)) dut_i (
    .bank_flat  (bank_flat),
    .sel_flat   (sel_flat),
    .lanes_flat (lanes_flat)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  function automatic logic [WB-1:0] exp_or(logic [NI-1:0] s);
    logic [WB-1:0] acc = '0;
    for (int i = 0; i < NI; i++) if (s[i]) acc |= bank_m[i];
    return acc;
  endfunction

  task automatic check(string req, int lane, logic [WB-1:0] exp);
    logic [WB-1:0] got = lanes_flat[lane*WB +: WB];
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s lane %0d: got %h expected %h", req, lane, got, exp);
    end
  endtask

  task automatic rand_bank();
    for (int i = 0; i < NI; i++) bank_m[i] = WB'($urandom);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    rand_bank();
    for (int j = 0; j < NO; j++) sel_m[j] = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    for (int j = 0; j < NO; j++) check("R4 reset idle", j, '0);

    // R1: bank layout, byte i holds i+1; lane j picks byte j+1
    @(negedge clk);
    for (int i = 0; i < NI; i++) bank_m[i] = WB'(i + 1);
    for (int j = 0; j < NO; j++) sel_m[j] = NI'(1) << (j + 1);
    #1;
    for (int j = 0; j < NO; j++) check("R1 layout", j, WB'(j + 2));

    // Full select sweep on each lane; other lanes random patterns (R3)
    for (int l = 0; l < NO; l++) begin
      for (int p = 0; p < (1 << NI); p++) begin
        @(negedge clk);
        rand_bank();
        for (int j = 0; j < NO; j++) sel_m[j] = NI'($urandom);
        sel_m[l] = NI'(p);
        #1;
        if (p == 0) check("R4 empty select", l, '0);
        else if ($countones(p) == 1) check("R2 one-hot", l, exp_or(NI'(p)));
        else check("R5 multi-hot OR", l, exp_or(NI'(p)));
        for (int j = 0; j < NO; j++) if (j != l) check("R3 other lane", j, exp_or(sel_m[j]));
      end
    end

    // Every one-hot combination across the lanes, reference by index
    for (int a = 0; a < NI; a++)
      for (int b = 0; b < NI; b++)
        for (int c = 0; c < NI; c++) begin
          @(negedge clk);
          rand_bank();
          sel_m[0] = NI'(1) << a;
          sel_m[1] = NI'(1) << b;
          sel_m[2] = NI'(1) << c;
          #1;
          check("R2 indexed", 0, bank_m[a]);
          check("R3 independent", 1, bank_m[b]);
          check("R3 independent", 2, bank_m[c]);
        end

    // R7 shared bank and R6 no clock edge between change and sample
    @(negedge clk);
    rand_bank();
    bank_m[2] = 4'h3;
    sel_m[0] = NI'(1) << 2;
    sel_m[1] = NI'(1) << 2;
    sel_m[2] = NI'(1) << 4;
    #0.5;
    bank_m[2] = 4'hC;
    #0.5;
    check("R7 shared pick", 0, 4'hC);
    check("R7 shared pick", 1, 4'hC);
    check("R7 untouched lane", 2, bank_m[4]);
    bank_m[4] = ~bank_m[4];
    #0.5;
    check("R6 follows without clock", 2, bank_m[4]);
    check("R7 untouched lane", 0, 4'hC);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule